// File: doc/BRIEF.md
# Dual-Pair Hot-Standby Failover Controller

The block watches four redundant compute streams arranged as two master/checker pairs. In each pair the checker's word is compared with the master's word every cycle. Only one pair is active at a time, and only its master word reaches the output. The other pair keeps receiving the same work, so its state stays current and it can take over at once. There is no majority vote. The only decision is whether the active pair still agrees with itself.

When the active pair's master and checker differ, the block marks that pair failed. In the same cycle it steers the output multiplexer to the standby pair, so the stream keeps flowing and the faulty word is never forwarded. A pair that disagrees with itself has its master gated off the multiplexer. The block also compares the two healthy masters with each other. A difference between them raises a diagnostic flag, but causes no switch, because nothing shows which pair is right. Failure state is sticky until reset.

Top module: `dual_pair_failover`

## Requirements
- R1: While reset is held and on the first cycle after it, active_idx is 0, pair_failed is 2'b00, and out_valid, fatal_err and pair_disagree are 0.
- R2: With no failure pending, out_data and out_valid one cycle later equal the master data and valid of the pair named by active_idx.
- R3: An internal mismatch in the active pair, while the standby pair is healthy, does three things at the next edge. It sets the active pair's bit in pair_failed (bit 0 for pair 0, bit 1 for pair 1). It flips active_idx. It registers the standby pair's master word and valid as that cycle's output.
- R4: If the active pair mismatches while the standby pair has already failed, fatal_err is set and stays set. From then on out_valid is 0 and out_data is 0.
- R5: A mismatch inside the standby pair sets its pair_failed bit. It leaves active_idx and the output unchanged, and rules out any later failover to that pair.
- R6: pair_disagree is 1 for one cycle after a cycle in which neither pair is failed or mismatching but the two masters differ. It never changes active_idx or pair_failed.
- R7: pair_failed bits, active_idx and fatal_err never revert on their own. A pair that recovers does not become active again. Only reset restores the R1 state.
- R8: Within a pair, "mismatch" means the valids differ, or both valids are 1 and the data differ. Two different words with both valids at 0 are not a mismatch. The same rule defines "masters differ" for R6.
- R9: A mismatch in both pairs in the same cycle sets both pair_failed bits and fatal_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m0_data | input | DATA_W | Pair 0 master word |
| m0_valid | input | 1 | Pair 0 master valid |
| c0_data | input | DATA_W | Pair 0 checker word |
| c0_valid | input | 1 | Pair 0 checker valid |
| m1_data | input | DATA_W | Pair 1 master word |
| m1_valid | input | 1 | Pair 1 master valid |
| c1_data | input | DATA_W | Pair 1 checker word |
| c1_valid | input | 1 | Pair 1 checker valid |
| out_data | output | DATA_W | Selected word, registered |
| out_valid | output | 1 | Selected valid, registered |
| active_idx | output | 1 | Index of the pair currently driving the output |
| pair_failed | output | 2 | Sticky failed flag per pair |
| pair_disagree | output | 1 | Healthy pairs' masters differed last cycle |
| fatal_err | output | 1 | Both pairs failed; output disabled |

## Verification
The bench targets failover on the very cycle of a mismatch. A design that switches one cycle late would forward the corrupted word. It also checks a standby pair that failed first: a design that ignores this would "fail over" into a broken pair instead of raising fatal_err. A disagreement between the pairs must not cause a switch, or the block would discard a good pair on evidence that proves nothing. Differing words with both valids low must not count as a mismatch, or idle noise would fail a healthy pair. Long pseudo-random runs with frequent resets also check that flags never clear on their own and that no switch-back occurs.

// File: rtl/fo_pkg.sv
package fo_pkg;
    localparam int unsigned NPAIR = 2;
    typedef logic [NPAIR-1:0] pair_vec_t;
endpackage

// File: rtl/fo_pair_compare.sv
module fo_pair_compare #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] m_data,
    input  logic              m_valid,
    input  logic [DATA_W-1:0] c_data,
    input  logic              c_valid,
    input  logic              failed_i,
    output logic              mismatch,
    output logic              healthy,
    output logic [DATA_W-1:0] g_data,
    output logic              g_valid
);
    always_comb begin
        mismatch = (m_valid != c_valid) || (m_valid && c_valid && (m_data != c_data));
        healthy  = !mismatch && !failed_i;
        // a pair that disagrees with itself is cut off the output mux
        g_data   = healthy ? m_data : '0;
        g_valid  = healthy && m_valid;
    end
endmodule

// File: rtl/fo_select.sv
module fo_select
    import fo_pkg::*;
(
    input  pair_vec_t healthy,
    input  logic      active_q,
    input  logic      fatal_q,
    output logic      sel,
    output logic      fatal_now
);
    always_comb begin
        sel       = active_q;
        fatal_now = fatal_q;
        if (!healthy[active_q]) begin
            if (healthy[!active_q]) begin
                sel = !active_q;
            end else begin
                fatal_now = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dual_pair_failover.sv
module dual_pair_failover
    import fo_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] m0_data,
    input  logic              m0_valid,
    input  logic [DATA_W-1:0] c0_data,
    input  logic              c0_valid,
    input  logic [DATA_W-1:0] m1_data,
    input  logic              m1_valid,
    input  logic [DATA_W-1:0] c1_data,
    input  logic              c1_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              active_idx,
    output logic [1:0]        pair_failed,
    output logic              pair_disagree,
    output logic              fatal_err
);
    typedef struct packed {
        logic              act;
        pair_vec_t         failed;
        logic              fatal;
        logic [DATA_W-1:0] odata;
        logic              ovalid;
        logic              disagree;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] md   [NPAIR];
    logic [DATA_W-1:0] cd   [NPAIR];
    logic [DATA_W-1:0] gd   [NPAIR];
    logic              mv   [NPAIR];
    logic              cv   [NPAIR];
    logic              gv   [NPAIR];
    pair_vec_t         mism;
    pair_vec_t         hlth;
    logic              sel;
    logic              fatal_now;

    assign md[0] = m0_data;  assign mv[0] = m0_valid;
    assign cd[0] = c0_data;  assign cv[0] = c0_valid;
    assign md[1] = m1_data;  assign mv[1] = m1_valid;
    assign cd[1] = c1_data;  assign cv[1] = c1_valid;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        fo_pair_compare #(.DATA_W(DATA_W)) u_cmp (
            .m_data   (md[p]),
            .m_valid  (mv[p]),
            .c_data   (cd[p]),
            .c_valid  (cv[p]),
            .failed_i (st_q.failed[p]),
            .mismatch (mism[p]),
            .healthy  (hlth[p]),
            .g_data   (gd[p]),
            .g_valid  (gv[p])
        );
    end

    fo_select u_sel (
        .healthy   (hlth),
        .active_q  (st_q.act),
        .fatal_q   (st_q.fatal),
        .sel       (sel),
        .fatal_now (fatal_now)
    );

    always_comb begin
        st_d          = st_q;
        st_d.failed   = st_q.failed | mism;
        st_d.fatal    = fatal_now;
        st_d.act      = fatal_now ? st_q.act : sel;
        st_d.odata    = fatal_now ? '0 : gd[sel];
        st_d.ovalid   = !fatal_now && gv[sel];
        // cross-pair compare is diagnostic only
        st_d.disagree = (&hlth) &&
                        ((mv[0] != mv[1]) || (mv[0] && mv[1] && (md[0] != md[1])));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data      = st_q.odata;
    assign out_valid     = st_q.ovalid;
    assign active_idx    = st_q.act;
    assign pair_failed   = st_q.failed;
    assign pair_disagree = st_q.disagree;
    assign fatal_err     = st_q.fatal;
endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] m0_data,
    input logic              m0_valid,
    input logic [DATA_W-1:0] c0_data,
    input logic              c0_valid,
    input logic [DATA_W-1:0] m1_data,
    input logic              m1_valid,
    input logic [DATA_W-1:0] c1_data,
    input logic              c1_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              active_idx,
    input logic [1:0]        pair_failed,
    input logic              pair_disagree,
    input logic              fatal_err
);
    AST_FATAL_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> (!out_valid && out_data == '0)); // R4
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err); // R4
    AST_FAIL0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pair_failed[0] |=> pair_failed[0]); // R7
    AST_FAIL1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pair_failed[1] |=> pair_failed[1]); // R7
    AST_NO_SWITCH_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        active_idx |=> active_idx); // R7
    AST_SWITCH_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        active_idx |-> pair_failed[0]); // R3
    AST_DISAGREE_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        pair_disagree |-> (pair_failed == 2'b00)); // R6
    AST_SAME_CYCLE_FAILOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!fatal_err && !active_idx && !pair_failed[1] && (m0_valid != c0_valid) &&
         (m1_valid == c1_valid) && (!m1_valid || m1_data == c1_data))
        |=> (active_idx && out_valid == $past(m1_valid) && out_data == $past(m1_data))); // R3
    AST_PASS_ACTIVE0: assert property (@(posedge clk) disable iff (!rst_n)
        (!fatal_err && !active_idx && !pair_failed[0] && (m0_valid == c0_valid) &&
         (!m0_valid || m0_data == c0_data))
        |=> (out_valid == $past(m0_valid) && out_data == $past(m0_data))); // R2
endmodule

bind dual_pair_failover fo_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dual_pair_failover.sv
module sim_dual_pair_failover;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] m0_data = '0, c0_data = '0, m1_data = '0, c1_data = '0;
    logic          m0_valid = 1'b0, c0_valid = 1'b0, m1_valid = 1'b0, c1_valid = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid, active_idx, pair_disagree, fatal_err;
    logic [1:0]    pair_failed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected-state model built from the requirements
    logic       e_act;
    logic [1:0] e_fail;
    logic       e_fatal;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pair_failover #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .m0_data(m0_data), .m0_valid(m0_valid), .c0_data(c0_data), .c0_valid(c0_valid),
        .m1_data(m1_data), .m1_valid(m1_valid), .c1_data(c1_data), .c1_valid(c1_valid),
        .out_data(out_data), .out_valid(out_valid), .active_idx(active_idx),
        .pair_failed(pair_failed), .pair_disagree(pair_disagree), .fatal_err(fatal_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic differ(input logic [DW-1:0] a, input logic av,
                                    input logic [DW-1:0] b, input logic bv);
        return (av != bv) || (av && bv && (a != b));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m0_valid = 0; c0_valid = 0; m1_valid = 0; c1_valid = 0;
        @(posedge clk); @(posedge clk); #1;
        check("R1", "active_idx", active_idx, 0);
        check("R1", "pair_failed", pair_failed, 0);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "fatal_err", fatal_err, 0);
        check("R1", "pair_disagree", pair_disagree, 0);
        @(negedge clk);
        rst_n = 1'b1;
        e_act = 0; e_fail = 0; e_fatal = 0;
    endtask

    task automatic step(input string tag,
                        input logic [DW-1:0] d0m, input logic v0m,
                        input logic [DW-1:0] d0c, input logic v0c,
                        input logic [DW-1:0] d1m, input logic v1m,
                        input logic [DW-1:0] d1c, input logic v1c);
        logic [1:0] mis, bad;
        logic sel, e_dis, e_v;
        logic [DW-1:0] e_d;
        @(negedge clk);
        m0_data = d0m; m0_valid = v0m; c0_data = d0c; c0_valid = v0c;
        m1_data = d1m; m1_valid = v1m; c1_data = d1c; c1_valid = v1c;
        mis[0] = differ(d0m, v0m, d0c, v0c);
        mis[1] = differ(d1m, v1m, d1c, v1c);
        bad = mis | e_fail;
        e_dis = !bad[0] && !bad[1] && differ(d0m, v0m, d1m, v1m);
        sel = e_act;
        if (bad[e_act]) begin
            if (!bad[!e_act]) sel = !e_act;
            else e_fatal = 1'b1;
        end
        if (!e_fatal) e_act = sel;
        e_fail = e_fail | mis;
        e_v = !e_fatal && (sel ? v1m : v0m);
        e_d = e_fatal ? '0 : (sel ? d1m : d0m);
        @(posedge clk); #1;
        check(tag, "out_valid", out_valid, e_v);
        if (e_v || e_fatal) check(tag, "out_data", out_data, e_d);
        check(tag, "active_idx", active_idx, e_act);
        check(tag, "pair_failed", pair_failed, e_fail);
        check(tag, "fatal_err", fatal_err, e_fatal);
        check(tag, "pair_disagree", pair_disagree, e_dis);
    endtask

    initial begin
        e_act = 0; e_fail = 0; e_fatal = 0;
        do_reset();
        // R2: every word through a healthy active pair
        for (int d = 0; d < 256; d++)
            step("R2", 8'(d), 1, 8'(d), 1, 8'(d), 1, 8'(d), 1);
        // R6: masters differ, both pairs self-consistent
        for (int d = 0; d < 16; d++)
            step("R6", 8'(d), 1, 8'(d), 1, 8'(d ^ 8'h5A), 1, 8'(d ^ 8'h5A), 1);
        step("R6", 8'h11, 1, 8'h11, 1, 8'h11, 0, 8'h11, 0);
        check("R6", "active_after_disagree", active_idx, 0);
        // R8: differing words with valids low are not a mismatch
        step("R8", 8'h0F, 0, 8'hF0, 0, 8'h33, 0, 8'hCC, 0);
        check("R8", "no_fail_idle_noise", pair_failed, 0);
        // R3: active mismatch on valid, switch in the same cycle
        step("R3", 8'hAA, 1, 8'hAA, 0, 8'h77, 1, 8'h77, 1);
        check("R3", "switched_word", out_data, 8'h77);
        check("R3", "switched_idx", active_idx, 1);
        // R7: pair 0 healthy again, no switch back
        for (int d = 0; d < 8; d++)
            step("R7", 8'(d), 1, 8'(d), 1, 8'(d + 100), 1, 8'(d + 100), 1);
        check("R7", "stays_on_pair1", active_idx, 1);
        // R4: the remaining pair fails
        step("R4", 8'h01, 1, 8'h01, 1, 8'h20, 1, 8'h21, 1);
        step("R4", 8'h02, 1, 8'h02, 1, 8'h30, 1, 8'h30, 1);
        check("R4", "fatal_sticky", fatal_err, 1);
        do_reset();
        check("R7", "reset_restores_idx", active_idx, 0);
        // R5: standby fails first, then active -> fatal, not failover
        step("R5", 8'h40, 1, 8'h40, 1, 8'h41, 1, 8'h42, 1);
        check("R5", "active_kept", active_idx, 0);
        step("R5", 8'h43, 1, 8'h43, 1, 8'h44, 1, 8'h44, 1);
        step("R5", 8'h45, 1, 8'h46, 1, 8'h47, 1, 8'h47, 1);
        check("R5", "no_failover_to_failed", fatal_err, 1);
        do_reset();
        // R9: both pairs mismatch together
        step("R9", 8'h10, 1, 8'h11, 1, 8'h20, 0, 8'h20, 1);
        check("R9", "both_failed", pair_failed, 3);
        // pseudo-random sweep with periodic resets
        for (int blk = 0; blk < 200; blk++) begin
            do_reset();
            for (int i = 0; i < 16; i++) begin
                logic [DW-1:0] a, b;
                logic va, vb;
                lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                a = lfsr[7:0]; b = lfsr[15:8]; va = lfsr[16]; vb = lfsr[17];
                step("R2", a, va, (lfsr[23:20] == 0) ? ~a : a, (lfsr[27:24] == 1) ? ~va : va,
                           lfsr[18] ? a : b, lfsr[18] ? va : vb,
                           (lfsr[31:28] == 2) ? b ^ 8'h01 : (lfsr[18] ? a : b),
                           (lfsr[31:28] == 3) ? ~(lfsr[18] ? va : vb) : (lfsr[18] ? va : vb));
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule